// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers four single-cycle event strobes from peripherals: two timer overflows, a waveform-generator event and a compare-channel event. It records each one in its own source pending bit. It then folds the events into two summary requests: one for timer overflows and one for the peripheral group made up of the waveform generator and the compare channel. An event reaches a summary bit only when its own source mask bit is set. Each summary bit is then gated a second time, by its own summary mask bit, to form an interrupt request line.

Software sees four byte-wide registers through a small register port. A source mask register is readable and writable. A source pending register is read-only, and any read of it empties the whole register, so software must keep the value it read and decode that copy afterwards. A summary pending register is cleared bit by bit, either by writing zero to a bit or by pulsing the matching acknowledge input. A summary mask register enables the two request lines.

Top module: `perint_agg`

## Requirements
- R1: Address 0 is the source mask, and it is read/write. Bit 0 enables timer 1, bit 2 enables timer 2, bit 4 enables the waveform generator and bit 6 enables the compare channel. Bits 1, 3, 5 and 7 always read as 1, and writing them has no effect.
- R2: Address 1 is the source pending register, with the same bit layout as R1. A strobe on a source sets its bit, seen from the cycle after the strobe, whatever the mask holds. Writes to address 1 have no effect, and its odd bits read as 1.
- R3: A read of address 1 returns the value held before the read. At the next edge all four source pending bits clear.
- R4: If a source strobe falls in the same cycle as a clearing read of address 1, that source's bit is still set afterwards.
- R5: Address 2 is the summary pending register. Bit 5 (the peripheral summary) is set from the cycle after a waveform or compare strobe whose source mask bit is set. A strobe whose mask bit is clear leaves bit 5 unchanged.
- R6: Bit 0 of address 2 (the timer summary) is set from the cycle after a timer-1 or timer-2 strobe whose mask bit is set. A strobe whose mask bit is clear leaves bit 0 unchanged.
- R7: Address 3 is the summary mask, with bit 5 for the peripheral group and bit 0 for the timer group. The other bits of address 3 read as 1. irq_per is high exactly when summary pending bit 5 and summary mask bit 5 are both 1. irq_tov is high exactly when both bit-0 values are 1.
- R8: A summary pending bit clears at the next edge when its acknowledge input is high, or when address 2 is written with that bit at 0. Writing a 1 to the bit has no effect. A setting event in the same cycle as a clear wins, and the bit stays set.
- R9: After reset, every mask and pending bit is 0 and both requests are low. Addresses 0 and 1 read 8'hAA, and addresses 2 and 3 read 8'hDE.
- R10: rdata is 0 in every cycle where cs and rd are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tmr1 | input | 1 | Timer 1 overflow strobe |
| ev_tmr2 | input | 1 | Timer 2 overflow strobe |
| ev_wave | input | 1 | Waveform-generator event strobe |
| ev_cmp | input | 1 | Compare-channel event strobe |
| ack_tov | input | 1 | Clears the timer summary bit |
| ack_per | input | 1 | Clears the peripheral summary bit |
| cs | input | 1 | Register port select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, valid while cs and rd are high) |
| irq_tov | output | 1 | Timer-overflow interrupt request |
| irq_per | output | 1 | Peripheral-group interrupt request |

## Verification
Two pairs of functions can fall in the same cycle: a source strobe with the clearing read of the source pending register, and a masked strobe with a summary clear (an acknowledge or a zero write). Directed cycles drive each pair together on purpose. A further stretch of random traffic makes such overlaps happen by chance. Every cycle, a behavioural model in the bench predicts the read data and both request lines. A lost event shows up as a mismatch in the read-back value, or in the request lines, on the following cycles.

// File: rtl/perint_pkg.sv
package perint_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int SRC_N   = 4;
    localparam int GRP_N   = 2;
    localparam int GRP_TOV = 0;
    localparam int GRP_PER = 1;
    localparam int TOV_POS = 0;
    localparam int PER_POS = 5;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SMASK = 2'd0,
        SEL_SPEND = 2'd1,
        SEL_UPEND = 2'd2,
        SEL_UMASK = 2'd3
    } reg_sel_e;

    // source i sits at bit 2*i: tmr1, tmr2, wave, cmp
    function automatic int src_pos(input int i);
        return 2 * i;
    endfunction

    function automatic int grp_pos(input int g);
        return (g == GRP_PER) ? PER_POS : TOV_POS;
    endfunction

    // sources 0,1 are timers; 2,3 form the peripheral group
    function automatic logic [SRC_N-1:0] grp_members(input int g);
        logic [SRC_N-1:0] m;
        for (int i = 0; i < SRC_N; i++) begin
            m[i] = ((i >= 2) == (g == GRP_PER));
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_src(input logic [SRC_N-1:0] v);
        logic [REG_W-1:0] r;
        r = '1;
        for (int i = 0; i < SRC_N; i++) begin
            r[src_pos(i)] = v[i];
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_grp(input logic [GRP_N-1:0] v);
        logic [REG_W-1:0] r;
        r = '1;
        for (int g = 0; g < GRP_N; g++) begin
            r[grp_pos(g)] = v[g];
        end
        return r;
    endfunction
endpackage

// File: rtl/perint_src_pend.sv
module perint_src_pend
    import perint_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    input  logic         clr_all,
    output logic [N-1:0] pend_q
);
    typedef struct packed {
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a strobe in the clearing cycle survives
            st_d.pend[i] = strobe[i] | (st_q.pend[i] & ~clr_all);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
endmodule

// File: rtl/perint_summary.sv
module perint_summary
    import perint_pkg::*;
#(
    parameter int N = SRC_N,
    parameter int G = GRP_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    input  logic [N-1:0] smask,
    input  logic [G-1:0] clr,
    output logic [G-1:0] sum_q
);
    typedef struct packed {
        logic [G-1:0] sum;
    } st_t;

    st_t          st_d, st_q;
    logic [G-1:0] set_g;

    for (genvar g = 0; g < G; g++) begin : g_grp
        assign set_g[g] = |(strobe & smask & grp_members(g));
    end

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < G; g++) begin
            st_d.sum[g] = set_g[g] | (st_q.sum[g] & ~clr[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_q = st_q.sum;
endmodule

// File: rtl/perint_regif.sv
module perint_regif
    import perint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [SRC_N-1:0]  spend,
    input  logic [GRP_N-1:0]  upend,
    output logic [SRC_N-1:0]  smask,
    output logic [GRP_N-1:0]  umask,
    output logic              spend_clr,
    output logic [GRP_N-1:0]  upend_wclr,
    output logic [REG_W-1:0]  rdata
);
    typedef struct packed {
        logic [SRC_N-1:0] smask;
        logic [GRP_N-1:0] umask;
    } regs_t;

    regs_t    rg_d, rg_q;
    logic     hit_rd, hit_wr;
    reg_sel_e sel;

    assign hit_rd = cs & rd;
    assign hit_wr = cs & wr;
    assign sel    = reg_sel_e'(addr);

    always_comb begin
        rg_d       = rg_q;
        spend_clr  = hit_rd && (sel == SEL_SPEND);
        upend_wclr = '0;
        rdata      = '0;
        if (hit_wr && sel == SEL_SMASK) begin
            for (int i = 0; i < SRC_N; i++) rg_d.smask[i] = wdata[src_pos(i)];
        end
        if (hit_wr && sel == SEL_UMASK) begin
            for (int g = 0; g < GRP_N; g++) rg_d.umask[g] = wdata[grp_pos(g)];
        end
        if (hit_wr && sel == SEL_UPEND) begin
            for (int g = 0; g < GRP_N; g++) upend_wclr[g] = ~wdata[grp_pos(g)];
        end
        if (hit_rd) begin
            case (sel)
                SEL_SMASK: rdata = pack_src(rg_q.smask);
                SEL_SPEND: rdata = pack_src(spend);
                SEL_UPEND: rdata = pack_grp(upend);
                SEL_UMASK: rdata = pack_grp(rg_q.umask);
                default:   rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign smask = rg_q.smask;
    assign umask = rg_q.umask;
endmodule

// File: rtl/perint_agg.sv
module perint_agg
    import perint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tmr1,
    input  logic              ev_tmr2,
    input  logic              ev_wave,
    input  logic              ev_cmp,
    input  logic              ack_tov,
    input  logic              ack_per,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq_tov,
    output logic              irq_per
);
    logic [SRC_N-1:0] ev_vec;
    logic [SRC_N-1:0] spend_q;
    logic [SRC_N-1:0] smask;
    logic [GRP_N-1:0] upend_q;
    logic [GRP_N-1:0] umask;
    logic [GRP_N-1:0] upend_wclr;
    logic [GRP_N-1:0] ack_vec;
    logic [GRP_N-1:0] upend_clr;
    logic             spend_clr;

    assign ev_vec    = {ev_cmp, ev_wave, ev_tmr2, ev_tmr1};
    assign ack_vec   = {ack_per, ack_tov};
    assign upend_clr = ack_vec | upend_wclr;

    perint_src_pend #(.N(SRC_N)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (ev_vec),
        .clr_all (spend_clr),
        .pend_q  (spend_q)
    );

    perint_summary #(.N(SRC_N), .G(GRP_N)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ev_vec),
        .smask  (smask),
        .clr    (upend_clr),
        .sum_q  (upend_q)
    );

    perint_regif u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .wr         (wr),
        .rd         (rd),
        .addr       (addr),
        .wdata      (wdata),
        .spend      (spend_q),
        .upend      (upend_q),
        .smask      (smask),
        .umask      (umask),
        .spend_clr  (spend_clr),
        .upend_wclr (upend_wclr),
        .rdata      (rdata)
    );

    assign irq_tov = upend_q[GRP_TOV] & umask[GRP_TOV];
    assign irq_per = upend_q[GRP_PER] & umask[GRP_PER];
endmodule

// File: rtl/perint_chk.sv
module perint_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_tmr1,
    input logic       ev_wave,
    input logic       ev_cmp,
    input logic       ack_per,
    input logic       cs,
    input logic       wr,
    input logic       rd,
    input logic [1:0] addr,
    input logic [7:0] rdata,
    input logic [3:0] spend_q,
    input logic [1:0] upend_q,
    input logic       irq_per
);
    // R2
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmp |=> spend_q[3]);

    // R3
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 2'd1 && !ev_tmr1 && !ev_wave && !ev_cmp) |=> (spend_q[2:0] == 3'b000 || spend_q[1] == 1'b1));

    // R5
    per_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upend_q[1]) |-> $past(ev_wave || ev_cmp));

    // R8
    per_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_per && !ev_wave && !ev_cmp) |=> !upend_q[1]);

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_per |-> upend_q[1]);

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == 8'h00));

    // R1
    rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr) |-> (rdata[7] == 1'b1));
endmodule

bind perint_agg perint_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_tmr1 (ev_tmr1),
    .ev_wave (ev_wave),
    .ev_cmp  (ev_cmp),
    .ack_per (ack_per),
    .cs      (cs),
    .wr      (wr),
    .rd      (rd),
    .addr    (addr),
    .rdata   (rdata),
    .spend_q (spend_q),
    .upend_q (upend_q),
    .irq_per (irq_per)
);

// File: tb/perint_agg_bench.sv
module perint_agg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_tmr1 = 1'b0, ev_tmr2 = 1'b0, ev_wave = 1'b0, ev_cmp = 1'b0;
    logic       ack_tov = 1'b0, ack_per = 1'b0;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_tov, irq_per;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference state: index 0 tmr1, 1 tmr2, 2 wave, 3 cmp
    bit sm[4];
    bit sp[4];
    bit up_tov, up_per, um_tov, um_per;

    always #10 clk = ~clk;

    perint_agg u_perint_agg (
        .clk(clk), .rst_n(rst_n),
        .ev_tmr1(ev_tmr1), .ev_tmr2(ev_tmr2), .ev_wave(ev_wave), .ev_cmp(ev_cmp),
        .ack_tov(ack_tov), .ack_per(ack_per),
        .cs(cs), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_tov(irq_tov), .irq_per(irq_per)
    );

    always @(posedge clk) begin
        bit ev[4];
        bit set_t, set_p, clr_t, clr_p;
        ev[0] = ev_tmr1; ev[1] = ev_tmr2; ev[2] = ev_wave; ev[3] = ev_cmp;
        cycles++;
        if (!rst_n) begin
            foreach (sm[i]) begin sm[i] = 0; sp[i] = 0; end
            up_tov = 0; up_per = 0; um_tov = 0; um_per = 0;
        end else begin
            set_t = (ev[0] && sm[0]) || (ev[1] && sm[1]);
            set_p = (ev[2] && sm[2]) || (ev[3] && sm[3]);
            clr_t = ack_tov || (cs && wr && addr == 2 && !wdata[0]);
            clr_p = ack_per || (cs && wr && addr == 2 && !wdata[5]);
            for (int i = 0; i < 4; i++) begin
                if (ev[i]) sp[i] = 1;
                else if (cs && rd && addr == 1) sp[i] = 0;
            end
            up_tov = set_t ? 1'b1 : (clr_t ? 1'b0 : up_tov);
            up_per = set_p ? 1'b1 : (clr_p ? 1'b0 : up_per);
            if (cs && wr && addr == 0)
                for (int i = 0; i < 4; i++) sm[i] = wdata[2*i];
            if (cs && wr && addr == 3) begin
                um_tov = wdata[0];
                um_per = wdata[5];
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        logic [7:0] r;
        r = 8'hFF;
        if (!(cs && rd)) return 8'h00;
        case (addr)
            2'd0: begin r[0] = sm[0]; r[2] = sm[1]; r[4] = sm[2]; r[6] = sm[3]; end
            2'd1: begin r[0] = sp[0]; r[2] = sp[1]; r[4] = sp[2]; r[6] = sp[3]; end
            2'd2: begin r[0] = up_tov; r[5] = up_per; end
            default: begin r[0] = um_tov; r[5] = um_per; end
        endcase
        return r;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic cyc(input logic [3:0] ev, input logic [1:0] ack, input logic c, input logic w,
                       input logic r, input logic [1:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        {ev_cmp, ev_wave, ev_tmr2, ev_tmr1} = ev;
        {ack_per, ack_tov} = ack;
        cs = c; wr = w; rd = r; addr = a; wdata = d;
        #1;
        check(rdata, exp_rdata(), req, "rdata");
        check({7'd0, irq_per}, {7'd0, bit'(up_per && um_per)}, "R7", "irq_per");
        check({7'd0, irq_tov}, {7'd0, bit'(up_tov && um_tov)}, "R7", "irq_tov");
    endtask

    task automatic rdr(input logic [1:0] a, input string req);
        cyc(4'b0, 2'b0, 1, 0, 1, a, 8'h00, req);
    endtask

    task automatic wrr(input logic [1:0] a, input logic [7:0] d, input string req);
        cyc(4'b0, 2'b0, 1, 1, 0, a, d, req);
    endtask

    task automatic idle(input string req);
        cyc(4'b0, 2'b0, 0, 0, 0, 2'd0, 8'h00, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset values
        rdr(0, "R9"); rdr(1, "R9"); rdr(2, "R9"); rdr(3, "R9");
        // R1 mask read/write, reserved bits
        wrr(0, 8'hFF, "R1"); rdr(0, "R1");
        wrr(0, 8'h00, "R1"); rdr(0, "R1");
        // R2 strobes with mask clear still latch; R5/R6 summary untouched
        cyc(4'b1111, 2'b0, 0, 0, 0, 0, 8'h00, "R2");
        rdr(2, "R5"); rdr(2, "R6");
        wrr(1, 8'h00, "R2");
        // R3 read returns then clears
        rdr(1, "R3"); rdr(1, "R3");
        // R4 strobe during clearing read
        cyc(4'b0100, 2'b0, 0, 0, 0, 0, 8'h00, "R4");
        cyc(4'b0001, 2'b0, 1, 0, 1, 1, 8'h00, "R4");
        rdr(1, "R4");
        // R5 masked wave event sets summary, R7 request
        wrr(0, 8'h10, "R5");
        cyc(4'b1000, 2'b0, 0, 0, 0, 0, 8'h00, "R5");
        rdr(2, "R5");
        cyc(4'b0100, 2'b0, 0, 0, 0, 0, 8'h00, "R5");
        rdr(2, "R5");
        wrr(3, 8'h21, "R7"); idle("R7"); rdr(3, "R7");
        // R8 ack clears, write-one no effect, write-zero clears
        cyc(4'b0, 2'b10, 0, 0, 0, 0, 8'h00, "R8"); rdr(2, "R8");
        cyc(4'b0100, 2'b0, 0, 0, 0, 0, 8'h00, "R8");
        wrr(2, 8'hFF, "R8"); rdr(2, "R8");
        wrr(2, 8'hDE, "R8"); rdr(2, "R8");
        // R8 set wins over ack
        cyc(4'b0100, 2'b10, 0, 0, 0, 0, 8'h00, "R8"); rdr(2, "R8");
        // R6 timer group
        wrr(0, 8'h04, "R6");
        cyc(4'b0001, 2'b0, 0, 0, 0, 0, 8'h00, "R6"); rdr(2, "R6");
        cyc(4'b0010, 2'b0, 0, 0, 0, 0, 8'h00, "R6"); rdr(2, "R6");
        cyc(4'b0010, 2'b01, 1, 1, 0, 2, 8'h00, "R8"); rdr(2, "R8");
        cyc(4'b0, 2'b01, 0, 0, 0, 0, 8'h00, "R8"); rdr(2, "R6");
        // R10 idle cycles with bus noise
        cyc(4'b0, 2'b0, 0, 0, 1, 2, 8'h00, "R10");
        cyc(4'b0, 2'b0, 1, 0, 0, 1, 8'h00, "R10");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            logic [3:0] ev;
            logic [1:0] ak;
            logic [1:0] a;
            string tg;
            ev = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            ak = 2'($urandom_range(0, 3)) & 2'($urandom_range(0, 3));
            a  = 2'($urandom_range(0, 3));
            case (a)
                2'd0: tg = "R1";
                2'd1: tg = "R3";
                2'd2: tg = "R5";
                default: tg = "R7";
            endcase
            cyc(ev, ak, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)), tg);
        end
        idle("R10");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule